// File: doc/BRIEF.md
# Dual-Stream Shift-Add Arithmetic Datapath

This block is a 16-bit arithmetic engine for a microcoded controller. Each cycle a microword supplies command fields, and one shared 16-bit operand bus feeds the datapath. The bus carries either an external input word or a word read from a 32-entry, 16-bit register file. The engine can move, add, subtract and shift left. It forms signed products and unsigned quotients as sequences of shift-and-add or shift-and-subtract steps, and it has no hardware multiplier.

Two independent instruction streams share the engine on alternate clocks. Each stream owns a complete set of working registers:
- a 16-bit held operand, loaded by its own command bit;
- a 32-bit accumulator, updated by the operation field;
- a 16-bit auxiliary register with an iteration counter, used during products and quotients.

The `stream` output names the stream whose cycle it is, so the sequencer knows which stream the next microword belongs to. Results leave as one 16-bit half of the current stream's accumulator. That half is written back to the register file, latched into the output register, or both.

Top module: `shiftadd_alu`

## Requirements
- R1: While reset is held, `dout` is 0 and both `busy` bits are 0. After reset is released, the first stream shown on `stream` is 0, and each stream's accumulator and held operand start at 0.
- R2: `stream` changes on every clock. A command acts only on the register set of the stream shown in its cycle, and the other set keeps its values.
- R3: The bus carries `rf[rd_addr]` when `src_rf` is 1 and carries `ext_in` when `src_rf` is 0.
- R4: The `acc_op` codes are:
  - 0 and 7: no operation.
  - 1: the accumulator takes the sign-extended bus.
  - 2: the accumulator takes held + bus.
  - 3: the accumulator takes held - bus.
  For codes 2 and 3, both operands are sign-extended to 32 bits. `hold_ld` loads the held operand from the bus on the same edge, and the operation uses the held value from before that edge.
- R5: With code 4, the accumulator is shifted left by `bus[4:0]` places, and zeros fill from the right.
- R6: Code 5 starts a signed 16x16 multiply of held x bus. The stream's `busy` bit stays high for exactly 32 clocks after the issuing edge, which is 16 of its own turns. When `busy` falls, the accumulator holds the 32-bit product.
- R7: Code 6 starts an unsigned divide of held / bus, with the same `busy` timing as R6. The quotient goes to accumulator bits [15:0] and the remainder to bits [31:16]. Dividing by zero gives a quotient of 0xFFFF and a remainder equal to the dividend.
- R8: While a stream is busy, its `acc_op` and `hold_ld` commands are ignored.
- R9: `wr_en` writes the selected half of the current stream's accumulator, as it was before the edge, into `rf[wr_addr]`. `res_hi` = 1 selects bits [31:16] and `res_hi` = 0 selects bits [15:0]. A read of the same entry in the same cycle returns the old contents.
- R10: `out_en` latches the same selected half into `dout`. Without `out_en`, `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | 16 | External operand word |
| src_rf | input | 1 | Bus source: 1 register file, 0 external input |
| rd_addr | input | 5 | Register file read index |
| hold_ld | input | 1 | Load the current stream's held operand from the bus |
| acc_op | input | 3 | Accumulator operation code (R4 to R7) |
| res_hi | input | 1 | Result half select for write-back and output |
| wr_en | input | 1 | Register file write strobe |
| wr_addr | input | 5 | Register file write index |
| out_en | input | 1 | Output register load strobe |
| dout | output | 16 | Output register |
| stream | output | 1 | Stream that owns the current cycle |
| busy | output | 2 | Per-stream iteration-in-progress flags |

## Verification
The assertions check the following on every clock:
- the stream indicator alternates;
- an off-turn register set does not move;
- a busy stream's held operand is frozen;
- `busy` only rises after a multiply or divide is issued on that stream's turn;
- a register file write lands on the next edge;
- `dout` holds when it is not loaded.

The arithmetic values need the bench's scenarios to show them. These cover signed products including the -32768 squared case, exact division, division by zero, carries into the upper half, shifts across the half boundary, read-during-write ordering, and the 32-clock busy window while the other stream keeps working.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MOVE = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SHL  = 3'd4,
    OP_MUL  = 3'd5,
    OP_DIV  = 3'd6,
    OP_RSV  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/sa_regfile.sv
module sa_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R9: a write is visible on the following cycle
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sa_lane.sv
module sa_lane
  import alu_pkg::*;
#(
  parameter int DW  = 16,
  localparam int AW = 2 * DW,
  localparam int CW = $clog2(DW + 1),
  localparam int SW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          turn,
  input  logic [DW-1:0] bus,
  input  logic          hold_ld,
  input  logic [2:0]    op,
  output logic [AW-1:0] acc,
  output logic          busy
);
  logic [DW-1:0] hold_q, hold_n, aux_q, aux_n;
  logic [AW-1:0] acc_q, acc_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, neg_q, neg_n, div_q, div_n;

  logic [DW:0]   psum;
  logic [AW-1:0] mstep, mfin, dstep;
  logic [AW:0]   dsh;
  logic [DW+1:0] ddiff;
  logic [DW-1:0] hold_mag, bus_mag;
  logic [AW-1:0] hold_sx, bus_sx;
  alu_op_e       opc;

  assign opc      = alu_op_e'(op);
  assign hold_sx  = {{DW{hold_q[DW-1]}}, hold_q};
  assign bus_sx   = {{DW{bus[DW-1]}}, bus};
  assign hold_mag = hold_q[DW-1] ? (~hold_q + 1'b1) : hold_q;
  assign bus_mag  = bus[DW-1] ? (~bus + 1'b1) : bus;

  // one shift-add multiply step: add multiplicand into upper half, shift right
  assign psum  = {1'b0, acc_q[AW-1:DW]} + (acc_q[0] ? {1'b0, aux_q} : '0);
  assign mstep = {psum, acc_q[DW-1:1]};
  assign mfin  = neg_q ? (~mstep + 1'b1) : mstep;

  // one restoring divide step: shift left, trial subtract
  assign dsh   = {acc_q, 1'b0};
  assign ddiff = {1'b0, dsh[AW:DW]} - {2'b0, aux_q};
  assign dstep = ddiff[DW+1] ? dsh[AW-1:0] : {ddiff[DW-1:0], dsh[DW-1:1], 1'b1};

  always_comb begin
    hold_n = hold_q;
    acc_n  = acc_q;
    aux_n  = aux_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    neg_n  = neg_q;
    div_n  = div_q;
    if (busy_q) begin
      if (div_q)              acc_n = dstep;
      else if (cnt_q == 1)    acc_n = mfin;
      else                    acc_n = mstep;
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == 1) busy_n = 1'b0;
    end else begin
      if (hold_ld) hold_n = bus;
      case (opc)
        OP_MOVE: acc_n = bus_sx;
        OP_ADD:  acc_n = hold_sx + bus_sx;
        OP_SUB:  acc_n = hold_sx - bus_sx;
        OP_SHL:  acc_n = acc_q << bus[SW-1:0];
        OP_MUL: begin
          acc_n  = {{DW{1'b0}}, bus_mag};
          aux_n  = hold_mag;
          neg_n  = hold_q[DW-1] ^ bus[DW-1];
          div_n  = 1'b0;
          cnt_n  = CW'(DW);
          busy_n = 1'b1;
        end
        OP_DIV: begin
          acc_n  = {{DW{1'b0}}, hold_q};
          aux_n  = bus;
          neg_n  = 1'b0;
          div_n  = 1'b1;
          cnt_n  = CW'(DW);
          busy_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      acc_q  <= '0;
      aux_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      div_q  <= 1'b0;
    end else if (turn) begin
      hold_q <= hold_n;
      acc_q  <= acc_n;
      aux_q  <= aux_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      neg_q  <= neg_n;
      div_q  <= div_n;
    end
  end

  assign acc  = acc_q;
  assign busy = busy_q;

  // R2: an off-turn register set does not move
  a_r2_offturn_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !turn |=> $stable(acc_q) && $stable(hold_q));
  // R8: a busy stream's held operand is frozen on its turn
  a_r8_busy_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (turn && busy_q) |=> $stable(hold_q));
  // R6 / R7: busy only rises after a multiply or divide issued on this turn
  a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(turn) && ($past(op) == 3'd5 || $past(op) == 3'd6));
endmodule

// File: rtl/shiftadd_alu.sv
module shiftadd_alu #(
  parameter int DW       = 16,
  parameter int RF_DEPTH = 32,
  localparam int IW      = $clog2(RF_DEPTH),
  localparam int AW      = 2 * DW,
  localparam int LANES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    ext_in,
  input  logic             src_rf,
  input  logic [IW-1:0]    rd_addr,
  input  logic             hold_ld,
  input  logic [2:0]       acc_op,
  input  logic             res_hi,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_addr,
  input  logic             out_en,
  output logic [DW-1:0]    dout,
  output logic             stream,
  output logic [LANES-1:0] busy
);
  logic [1:0]    sync_q;
  logic          srst_n;
  logic          phase_q, run_q;
  logic [DW-1:0] rf_rdata, bus, result, dout_q, dout_n;
  logic [AW-1:0] lane_acc [LANES];
  logic [AW-1:0] cur_acc;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      run_q   <= 1'b1;
    end
  end

  sa_regfile #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
    .clk   (clk),
    .rst_n (srst_n),
    .we    (wr_en & srst_n),
    .waddr (wr_addr),
    .wdata (result),
    .raddr (rd_addr),
    .rdata (rf_rdata)
  );

  assign bus = src_rf ? rf_rdata : ext_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sa_lane #(.DW(DW)) u_lane (
      .clk     (clk),
      .rst_n   (srst_n),
      .turn    (phase_q == 1'(i)),
      .bus     (bus),
      .hold_ld (hold_ld),
      .op      (acc_op),
      .acc     (lane_acc[i]),
      .busy    (busy[i])
    );
  end

  assign cur_acc = lane_acc[phase_q];
  assign result  = res_hi ? cur_acc[AW-1:DW] : cur_acc[DW-1:0];
  assign dout_n  = out_en ? result : dout_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) dout_q <= '0;
    else         dout_q <= dout_n;
  end

  assign dout   = dout_q;
  assign stream = phase_q;

  // R2: streams take turns on every clock
  a_r2_stream_alternates: assert property (@(posedge clk) disable iff (!srst_n)
    run_q |=> stream != $past(stream));
  // R10: output register holds without a load strobe
  a_r10_dout_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !out_en |=> $stable(dout));
endmodule

// File: tb/shiftadd_alu_test.sv
`timescale 1ns/1ps
module shiftadd_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ext_in;
  logic        src_rf, hold_ld, res_hi, wr_en, out_en;
  logic [4:0]  rd_addr, wr_addr;
  logic [2:0]  acc_op;
  logic [15:0] dout;
  logic        stream;
  logic [1:0]  busy;

  int tests = 0;
  int fails = 0;
  int busy0_cnt = 0;

  // behavioural reference state
  logic [15:0] mrf [32];
  logic [15:0] mhold [2];
  logic [31:0] macc [2];
  logic [31:0] mpend [2];
  int          mbcnt [2];
  logic [15:0] mdout;
  logic        mph;

  always #2 clk = ~clk;

  shiftadd_alu uut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .src_rf(src_rf), .rd_addr(rd_addr),
    .hold_ld(hold_ld), .acc_op(acc_op), .res_hi(res_hi), .wr_en(wr_en),
    .wr_addr(wr_addr), .out_en(out_en), .dout(dout), .stream(stream), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      mhold[i] = '0; macc[i] = '0; mpend[i] = '0; mbcnt[i] = 0;
    end
    mdout = '0;
  endtask

  task automatic cyc(input logic s_rf, input logic [4:0] rd, input logic [15:0] ext,
                     input logic hl, input logic [2:0] op, input logic hi,
                     input logic we, input logic [4:0] wa, input logic oe);
    logic [15:0] res, b;
    logic [31:0] hx, bx;
    int p;
    src_rf = s_rf; rd_addr = rd; ext_in = ext; hold_ld = hl; acc_op = op;
    res_hi = hi; wr_en = we; wr_addr = wa; out_en = oe;
    p   = int'(mph);
    res = hi ? macc[p][31:16] : macc[p][15:0];
    b   = s_rf ? mrf[rd] : ext;
    hx  = {{16{mhold[p][15]}}, mhold[p]};
    bx  = {{16{b[15]}}, b};
    if (we) mrf[wa] = res;
    if (oe) mdout = res;
    if (mbcnt[p] != 0) begin
      mbcnt[p]--;
      if (mbcnt[p] == 0) macc[p] = mpend[p];
    end else begin
      case (op)
        3'd1: macc[p] = bx;
        3'd2: macc[p] = hx + bx;
        3'd3: macc[p] = hx - bx;
        3'd4: macc[p] = macc[p] << b[4:0];
        3'd5: begin mpend[p] = $signed(hx) * $signed(bx); mbcnt[p] = 16; end
        3'd6: begin
          if (b == 0) mpend[p] = {mhold[p], 16'hFFFF};
          else        mpend[p] = {mhold[p] % b, mhold[p] / b};
          mbcnt[p] = 16;
        end
        default: ;
      endcase
      if (hl) mhold[p] = b;
    end
    mph = ~mph;
    @(posedge clk);
    @(negedge clk);
    check("R10 dout", {16'h0, dout}, {16'h0, mdout});
    check("R6 busy0", {31'h0, busy[0]}, {31'h0, mbcnt[0] != 0});
    check("R7 busy1", {31'h0, busy[1]}, {31'h0, mbcnt[1] != 0});
    check("R2 stream", {31'h0, stream}, {31'h0, mph});
    if (busy[0]) busy0_cnt++;
  endtask

  task automatic run(input logic s, input logic [2:0] op, input logic [15:0] ext,
                     input logic hl, input logic oe, input logic hi, input logic we,
                     input logic [4:0] wa, input logic s_rf, input logic [4:0] rd);
    while (mph != s) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(s_rf, rd, ext, hl, op, hi, we, wa, oe);
  endtask

  task automatic show(input logic s, input logic hi);
    run(s, 3'd0, 16'h0, 0, 1, hi, 0, 5'd0, 0, 5'd0);
  endtask

  task automatic wait_idle();
    while (mbcnt[0] != 0 || mbcnt[1] != 0) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    src_rf = 0; rd_addr = 0; ext_in = 0; hold_ld = 0; acc_op = 0;
    res_hi = 0; wr_en = 0; wr_addr = 0; out_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset dout", {16'h0, dout}, 32'h0);
    check("R1 reset busy", {30'h0, busy}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 first stream", {31'h0, stream}, 32'h0);
    mph = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: cleared accumulator seen through the output path
    show(0, 0); check("R1 acc cleared", {16'h0, dout}, 32'h0);

    // R3: bus from register file and from external input
    run(0, 3'd1, 16'h1234, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd0, 16'h0, 0, 0, 0, 1, 5'd3, 0, 5'd0);
    run(1, 3'd1, 16'h0, 0, 0, 0, 0, 5'd0, 1, 5'd3);
    show(1, 0); check("R3 rf source", {16'h0, dout}, 32'h1234);
    run(1, 3'd1, 16'hA5A5, 0, 0, 0, 0, 5'd0, 0, 5'd3);
    show(1, 0); check("R3 ext source", {16'h0, dout}, 32'hA5A5);

    // R9: same-cycle read returns old contents, write lands after
    run(0, 3'd1, 16'h0055, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd1, 16'h0, 0, 0, 0, 1, 5'd3, 1, 5'd3);
    show(0, 0); check("R9 old on read", {16'h0, dout}, 32'h1234);
    run(0, 3'd1, 16'h0, 0, 0, 0, 0, 5'd0, 1, 5'd3);
    show(0, 0); check("R9 new after", {16'h0, dout}, 32'h0055);
    run(1, 3'd0, 16'h0, 0, 0, 1, 1, 5'd7, 0, 5'd0);
    run(0, 3'd1, 16'h0, 0, 0, 0, 0, 5'd0, 1, 5'd7);
    show(0, 0); check("R9 upper half", {16'h0, dout}, 32'hFFFF);

    // R4: add and subtract with sign extension
    run(0, 3'd1, 16'h7FFF, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd2, 16'h0001, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(0, 0); check("R4 add lo", {16'h0, dout}, 32'h8000);
    show(0, 1); check("R4 add hi", {16'h0, dout}, 32'h0000);
    run(0, 3'd3, 16'h8000, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(0, 0); check("R4 sub lo", {16'h0, dout}, 32'hFFFF);
    show(0, 1); check("R4 sub hi", {16'h0, dout}, 32'h0000);
    run(0, 3'd1, 16'h0001, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd3, 16'h0002, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(0, 1); check("R4 sub negative", {16'h0, dout}, 32'hFFFF);
    run(0, 3'd7, 16'h0123, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(0, 0); check("R4 reserved code", {16'h0, dout}, 32'hFFFF);

    // R5: shift across the half boundary
    run(0, 3'd1, 16'h0003, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd4, 16'h0014, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(0, 1); check("R5 shl hi", {16'h0, dout}, 32'h0030);
    show(0, 0); check("R5 shl lo", {16'h0, dout}, 32'h0000);

    // R6, R7, R8: concurrent multiply and divide, commands to busy stream
    run(0, 3'd1, 16'hFFFD, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(1, 3'd1, 16'h0064, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    while (mph != 1'b0) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    busy0_cnt = 0;
    run(0, 3'd5, 16'h0007, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    run(1, 3'd6, 16'h0007, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd2, 16'h1111, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    wait_idle();
    check("R6 busy window", busy0_cnt, 32);
    show(0, 0); check("R6 mul lo", {16'h0, dout}, 32'hFFEB);
    show(0, 1); check("R6 mul hi", {16'h0, dout}, 32'hFFFF);
    show(1, 0); check("R7 quotient", {16'h0, dout}, 32'h000E);
    show(1, 1); check("R7 remainder", {16'h0, dout}, 32'h0002);
    run(0, 3'd2, 16'h0000, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(0, 0); check("R8 hold kept", {16'h0, dout}, 32'hFFFD);

    // R6: most negative squared
    run(0, 3'd1, 16'h8000, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd5, 16'h8000, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    wait_idle();
    show(0, 1); check("R6 min sq hi", {16'h0, dout}, 32'h4000);
    show(0, 0); check("R6 min sq lo", {16'h0, dout}, 32'h0000);

    // R7: divide by zero and a large unsigned dividend
    run(1, 3'd1, 16'hBEEF, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(1, 3'd6, 16'h0000, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    wait_idle();
    show(1, 0); check("R7 div0 quotient", {16'h0, dout}, 32'hFFFF);
    show(1, 1); check("R7 div0 remainder", {16'h0, dout}, 32'hBEEF);
    run(1, 3'd1, 16'hFFFF, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(1, 3'd6, 16'h0010, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    wait_idle();
    show(1, 0); check("R7 unsigned q", {16'h0, dout}, 32'h0FFF);
    show(1, 1); check("R7 unsigned r", {16'h0, dout}, 32'h000F);

    // R2: other stream keeps working while one is busy
    run(0, 3'd1, 16'h0100, 1, 0, 0, 0, 5'd0, 0, 5'd0);
    run(0, 3'd5, 16'h0003, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    run(1, 3'd1, 16'h0042, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    show(1, 0); check("R2 other stream", {16'h0, dout}, 32'h0042);
    check("R2 still busy", {31'h0, busy[0]}, 32'h1);
    wait_idle();
    show(0, 0); check("R2 busy stream result", {16'h0, dout}, 32'h0300);

    // R10: dout holds without a load strobe
    repeat (5) cyc(0, 0, 16'h7777, 0, 3'd1, 0, 0, 0, 0);
    check("R10 dout held", {16'h0, dout}, 32'h0300);

    // R1: reset in mid-run
    run(0, 3'd5, 16'h0005, 0, 0, 0, 0, 5'd0, 0, 5'd0);
    do_reset();
    show(0, 0); check("R1 acc after reset", {16'h0, dout}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule